// File: doc/BRIEF.md
# Video Memory Host Access Port

This block connects a host processor to a video processor through two byte-wide ports. The control port takes bytes in pairs. The second byte of each pair says what to do with the first. It either stores the first byte into one of the processor's internal control registers, or it loads the low 14 bits of the video memory pointer and sets the transfer direction. The data port then moves bytes between the host and video memory at the pointer. After every data-port access the pointer steps up by one.

The video memory is 128 KB, which needs a 17-bit address. The three top address bits come from a bank field in one of the control registers. A mode input sets where the pointer wraps. When it is low, the pointer wraps inside a 16 KB window and the bank stays where it is. When it is high, the carry out of the low 14 bits increments the bank, so the pointer runs through the whole 128 KB and wraps only after the last byte.

Reads are prefetched. When a read is set up, the byte at the pointer is fetched from the synchronous memory into a read latch. Each host read returns the latch, advances the pointer and fetches the next byte. Every control register is presented in parallel on a flat bus to the display logic that uses it. The host must leave at least three clock cycles between accesses.

Top module: `vdp_host_port`

## Requirements
- R1: After reset every control register is 0, the pointer and bank address 0, the read latch is 0 and the control port expects a first byte.
- R2: A control pair whose second byte has bit 7 set writes the first byte into the register numbered by bits 5..0 of the second byte. The pointer is not changed.
- R3: A register write to a number of NUM_REGS or above changes no register.
- R4: A control pair whose second byte has bit 7 clear loads pointer bits 13..8 from bits 5..0 of that byte and bits 7..0 from the first byte. Address bits 16..14 come from bits 2..0 of register BANK_REG (14 by default).
- R5: Bit 6 of a pointer-setup byte chooses the direction. A value of 1 (write) issues no memory read. A value of 0 (read) fetches the byte at the new pointer into the read latch.
- R6: A data-port write stores the byte at the current 17-bit address, and the pointer then steps up by one.
- R7: A data-port read returns the latched byte, steps the pointer up and refetches, so consecutive reads return consecutive memory bytes.
- R8: With the wide-wrap input low, the pointer steps from 0x3FFF to 0x0000 and the bank field does not change.
- R9: With the wide-wrap input high, a carry out of pointer bit 13 increments the bank field, so 0x07FFF is followed by 0x08000 and 0x1FFFF by 0x00000. Register bits 7..3 of the bank register are kept.
- R10: Any data-port access returns the control port to expecting a first byte.
- R11: A data-port write while the direction is read still stores the byte and steps the pointer.
- R12: The memory write strobe, address and data appear in the same cycle as the host data-port write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_wrap | input | 1 | 1: 128 KB pointer wrap with bank carry; 0: 16 KB wrap |
| ctl_wr | input | 1 | Control-port byte strobe |
| ctl_wdata | input | 8 | Control-port byte |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_rd | input | 1 | Data-port read strobe |
| dat_rdata | output | 8 | Read latch contents |
| reg_bus | output | NUM_REGS*8 | All control registers, register i in bits i*8+7..i*8 |
| vram_addr | output | 17 | Memory address (bank and pointer) |
| vram_we | output | 1 | Memory write strobe |
| vram_wdata | output | 8 | Memory write byte |
| vram_re | output | 1 | Memory read strobe |
| vram_rdata | input | 8 | Memory read byte, valid the cycle after vram_re |

## Verification
The bench builds the block with its default parameters: 16 control registers, the bank in register 14, and a 3-bit bank. With these values it can write every one of the 64 encodable register numbers, so both the implemented registers and the ignored numbers are covered. It can also step through all eight banks and drive the pointer across each wrap point in both modes. The memory model returns a byte that is computed from the address wherever nothing has been written, so a read at a wrong address shows up at once.

// File: rtl/vdp_host_pkg.sv
package vdp_host_pkg;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 6;
    localparam int LOW_W   = 14;
    localparam int HI_W    = LOW_W - BYTE_W;

    typedef struct packed {
        logic              reg_wr;
        logic [SEL_W-1:0]  reg_sel;
        logic [BYTE_W-1:0] reg_data;
        logic              ptr_set;
        logic              ptr_dir_wr;
        logic [LOW_W-1:0]  ptr_val;
    } ctl_cmd_t;

    typedef struct packed {
        logic [LOW_W-1:0]  ptr;
        logic              fetch;
        logic              pend;
        logic [BYTE_W-1:0] latch;
    } ptr_state_t;
endpackage

// File: rtl/vdp_ctl_seq.sv
module vdp_ctl_seq
    import vdp_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    input  logic              data_acc,
    output logic              cmd_reg_wr,
    output logic [SEL_W-1:0]  cmd_reg_sel,
    output logic [BYTE_W-1:0] cmd_reg_data,
    output logic              cmd_ptr_set,
    output logic              cmd_ptr_dir_wr,
    output logic [LOW_W-1:0]  cmd_ptr_val
);
    typedef struct packed {
        logic              second;
        logic [BYTE_W-1:0] first;
    } seq_t;

    seq_t     s_d, s_q;
    ctl_cmd_t cmd;

    always_comb begin
        s_d = s_q;
        cmd = '0;
        if (data_acc) begin
            s_d.second = 1'b0;
        end else if (ctl_wr) begin
            if (!s_q.second) begin
                s_d.first  = ctl_wdata;
                s_d.second = 1'b1;
            end else begin
                s_d.second = 1'b0;
                if (ctl_wdata[7]) begin
                    cmd.reg_wr   = 1'b1;
                    cmd.reg_sel  = ctl_wdata[SEL_W-1:0];
                    cmd.reg_data = s_q.first;
                end else begin
                    cmd.ptr_set    = 1'b1;
                    cmd.ptr_dir_wr = ctl_wdata[6];
                    cmd.ptr_val    = {ctl_wdata[HI_W-1:0], s_q.first};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_reg_wr     = cmd.reg_wr;
    assign cmd_reg_sel    = cmd.reg_sel;
    assign cmd_reg_data   = cmd.reg_data;
    assign cmd_ptr_set    = cmd.ptr_set;
    assign cmd_ptr_dir_wr = cmd.ptr_dir_wr;
    assign cmd_ptr_val    = cmd.ptr_val;

    // R10
    toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> !s_q.second);
endmodule

// File: rtl/vdp_reg_file.sv
module vdp_reg_file
    import vdp_host_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int BANK_REG = 14,
    parameter int BANK_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       bank_inc,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_d, regs_q;
    logic                            in_range;

    assign in_range = (int'(wr_sel) < NUM_REGS);

    always_comb begin
        regs_d = regs_q;
        if (wr_en && in_range)
            regs_d[wr_sel[IDX_W-1:0]] = wr_data;
        if (bank_inc)
            regs_d[BANK_REG][BANK_W-1:0] = regs_q[BANK_REG][BANK_W-1:0] + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    // R3
    oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range && !bank_inc) |=> (regs_q == $past(regs_q)));
    // R9
    bank_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_inc && !wr_en) |=>
        (regs_q[BANK_REG][BANK_W-1:0] == BANK_W'($past(regs_q[BANK_REG][BANK_W-1:0]) + 1'b1)));
endmodule

// File: rtl/vdp_vram_ptr.sv
module vdp_vram_ptr
    import vdp_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_wrap,
    input  logic              set_en,
    input  logic              set_dir_wr,
    input  logic [LOW_W-1:0]  set_val,
    input  logic              wr_acc,
    input  logic              rd_acc,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [LOW_W-1:0]  ptr_o,
    output logic              mem_re,
    output logic              bank_carry,
    output logic [BYTE_W-1:0] latch_o
);
    ptr_state_t     st_d, st_q;
    logic [LOW_W:0] step;

    assign step   = {1'b0, st_q.ptr} + 1'b1;
    assign mem_re = st_q.fetch && !wr_acc;

    always_comb begin
        st_d       = st_q;
        bank_carry = 1'b0;
        st_d.pend  = mem_re;
        if (mem_re) st_d.fetch = 1'b0;
        if (st_q.pend) st_d.latch = mem_rdata;
        if (wr_acc || rd_acc) begin
            st_d.ptr   = step[LOW_W-1:0];
            bank_carry = step[LOW_W] && wide_wrap;
            if (rd_acc) st_d.fetch = 1'b1;
        end else if (set_en) begin
            st_d.ptr   = set_val;
            st_d.fetch = !set_dir_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o   = st_q.ptr;
    assign latch_o = st_q.latch;

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc || rd_acc) |=> (st_q.ptr == LOW_W'($past(st_q.ptr) + 1'b1)));
    // R5
    read_prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !set_dir_wr && !wr_acc && !rd_acc) |=> st_q.fetch);
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_host_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int BANK_REG = 14,
    parameter int BANK_W   = 3,
    localparam int ADDR_W  = LOW_W + BANK_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wide_wrap,
    input  logic                       ctl_wr,
    input  logic [BYTE_W-1:0]          ctl_wdata,
    input  logic                       dat_wr,
    input  logic [BYTE_W-1:0]          dat_wdata,
    input  logic                       dat_rd,
    output logic [BYTE_W-1:0]          dat_rdata,
    output logic [NUM_REGS*BYTE_W-1:0] reg_bus,
    output logic [ADDR_W-1:0]          vram_addr,
    output logic                       vram_we,
    output logic [BYTE_W-1:0]          vram_wdata,
    output logic                       vram_re,
    input  logic [BYTE_W-1:0]          vram_rdata
);
    logic              reg_wr, ptr_set, ptr_dir_wr, bank_carry;
    logic [SEL_W-1:0]  reg_sel;
    logic [BYTE_W-1:0] reg_data;
    logic [LOW_W-1:0]  ptr_val, ptr_cur;
    logic [BANK_W-1:0] bank;

    vdp_ctl_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .data_acc(dat_wr || dat_rd),
        .cmd_reg_wr(reg_wr), .cmd_reg_sel(reg_sel), .cmd_reg_data(reg_data),
        .cmd_ptr_set(ptr_set), .cmd_ptr_dir_wr(ptr_dir_wr), .cmd_ptr_val(ptr_val)
    );

    vdp_reg_file #(.NUM_REGS(NUM_REGS), .BANK_REG(BANK_REG), .BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
        .wr_data(reg_data), .bank_inc(bank_carry), .regs_o(reg_bus)
    );

    vdp_vram_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .wide_wrap(wide_wrap),
        .set_en(ptr_set), .set_dir_wr(ptr_dir_wr), .set_val(ptr_val),
        .wr_acc(dat_wr), .rd_acc(dat_rd), .mem_rdata(vram_rdata),
        .ptr_o(ptr_cur), .mem_re(vram_re), .bank_carry(bank_carry),
        .latch_o(dat_rdata)
    );

    assign bank       = reg_bus[BANK_REG*BYTE_W +: BANK_W];
    assign vram_addr  = {bank, ptr_cur};
    assign vram_we    = dat_wr;
    assign vram_wdata = dat_wdata;

    // R8
    narrow_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_wr || dat_rd) && !wide_wrap && !reg_wr) |=> $stable(bank));
    // R12
    mem_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vram_we && vram_re));
endmodule

// File: tb/vdp_host_port_bench.sv
module vdp_host_port_bench;
    localparam int NR = 16;
    localparam int BR = 14;

    logic clk = 0, rst_n = 0, wide_wrap = 0;
    logic ctl_wr = 0, dat_wr = 0, dat_rd = 0;
    logic [7:0] ctl_wdata = 0, dat_wdata = 0, dat_rdata, vram_wdata;
    logic [7:0] vram_rdata = 0;
    logic [NR*8-1:0] reg_bus;
    logic [16:0] vram_addr;
    logic vram_we, vram_re;

    int tests = 0, fails = 0, re_cnt = 0;
    logic [7:0] mem [int];
    logic [7:0] exp_regs [NR];
    logic [13:0] exp_low;

    always #10 clk = ~clk;

    vdp_host_port u_vdp_host_port (
        .clk(clk), .rst_n(rst_n), .wide_wrap(wide_wrap),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .dat_rd(dat_rd), .dat_rdata(dat_rdata), .reg_bus(reg_bus),
        .vram_addr(vram_addr), .vram_we(vram_we), .vram_wdata(vram_wdata),
        .vram_re(vram_re), .vram_rdata(vram_rdata)
    );

    function automatic logic [7:0] fill(int a);
        return 8'((a * 7) ^ (a >> 8) ^ (a >> 13));
    endfunction

    function automatic logic [7:0] mem_at(int a);
        return mem.exists(a) ? mem[a] : fill(a);
    endfunction

    always @(posedge clk) begin
        if (vram_re) begin
            vram_rdata <= mem_at(int'(vram_addr));
            re_cnt <= re_cnt + 1;
        end
        if (vram_we) mem[int'(vram_addr)] = vram_wdata;
    end

    function automatic logic [16:0] exp_addr();
        return {exp_regs[BR][2:0], exp_low};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gap();
        repeat (3) @(negedge clk);
    endtask

    task automatic ctl(logic [7:0] b);
        @(negedge clk); ctl_wr = 1; ctl_wdata = b;
        @(negedge clk); ctl_wr = 0; gap();
    endtask

    task automatic set_reg(int idx, logic [7:0] v);
        ctl(v); ctl(8'h80 | 8'(idx));
        if (idx < NR) exp_regs[idx] = v;
    endtask

    task automatic set_ptr(logic [13:0] a, bit wr);
        ctl(a[7:0]); ctl({1'b0, wr, a[13:8]});
        exp_low = a;
    endtask

    task automatic step_exp();
        logic [14:0] s;
        s = {1'b0, exp_low} + 1'b1;
        exp_low = s[13:0];
        if (s[14] && wide_wrap) exp_regs[BR][2:0] = exp_regs[BR][2:0] + 1'b1;
    endtask

    task automatic dwrite(logic [7:0] b);
        logic [16:0] a;
        a = exp_addr();
        @(negedge clk); dat_wr = 1; dat_wdata = b;
        #1;
        check("R12", {vram_we, vram_addr, vram_wdata}, {1'b1, a, b});
        @(negedge clk); dat_wr = 0;
        step_exp();
        gap();
        check("R6", mem_at(int'(a)), b);
    endtask

    task automatic dread(string req);
        logic [16:0] a;
        a = exp_addr();
        @(negedge clk);
        check(req, dat_rdata, mem_at(int'(a)));
        dat_rd = 1;
        @(negedge clk); dat_rd = 0;
        step_exp();
        gap();
    endtask

    task automatic check_regs(string req);
        logic ok;
        ok = 1;
        for (int i = 0; i < NR; i++) if (reg_bus[i*8 +: 8] !== exp_regs[i]) ok = 0;
        check(req, ok, 1);
    endtask

    initial begin
        #4000000;
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rc;
        for (int i = 0; i < NR; i++) exp_regs[i] = 0;
        exp_low = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_regs("R1");
        check("R1", {vram_addr, dat_rdata}, 0);

        // R2 / R3 sweep of all 64 register numbers
        for (int i = 0; i < 64; i++) begin
            set_reg(i, 8'(i * 37 + 5));
            check_regs(i < NR ? "R2" : "R3");
            check("R2", vram_addr, exp_addr());
        end

        // R4 / R5 / R6 writes in every bank, write setup issues no read
        wide_wrap = 0;
        for (int b = 0; b < 8; b++) begin
            set_reg(BR, 8'(b) | 8'hA8);
            rc = re_cnt;
            set_ptr(14'(b * 1111 + 3), 1);
            check("R4", vram_addr, exp_addr());
            dwrite(8'(b + 8'h40));
            dwrite(8'(b + 8'h50));
            check("R5", re_cnt, rc);
            check("R6", vram_addr, exp_addr());
        end

        // R5 / R7 read back a written block then untouched bytes
        set_reg(BR, 8'h03);
        set_ptr(14'h0100, 1);
        for (int k = 0; k < 4; k++) dwrite(8'(8'hC0 + k));
        set_ptr(14'h00FE, 0);
        for (int k = 0; k < 8; k++) dread("R7");
        check("R7", vram_addr, exp_addr());

        // R8 narrow wrap keeps bank
        wide_wrap = 0;
        set_reg(BR, 8'h05);
        set_ptr(14'h3FFE, 1);
        for (int k = 0; k < 3; k++) dwrite(8'(8'h90 + k));
        check("R8", vram_addr, 17'h14001);
        check("R8", reg_bus[BR*8 +: 8], 8'h05);
        set_ptr(14'h3FFE, 0);
        for (int k = 0; k < 3; k++) dread("R8");

        // R9 wide wrap carries into bank
        wide_wrap = 1;
        set_reg(BR, 8'hF1);
        set_ptr(14'h3FFF, 1);
        dwrite(8'h11); dwrite(8'h22);
        check("R9", vram_addr, 17'h08001);
        check("R9", reg_bus[BR*8 +: 8], 8'hF2);
        set_reg(BR, 8'h37);
        set_ptr(14'h3FFE, 0);
        for (int k = 0; k < 4; k++) dread("R9");
        check("R9", vram_addr, 17'h00002);
        check("R9", reg_bus[BR*8 +: 8], 8'h30);
        wide_wrap = 0;

        // R10 data access clears a pending first byte
        ctl(8'h12);
        dwrite(8'h77);
        set_reg(3, 8'h55);
        check("R10", reg_bus[3*8 +: 8], 8'h55);
        check_regs("R10");

        // R11 write while direction is read
        set_reg(BR, 8'h02);
        set_ptr(14'h0A0A, 0);
        repeat (2) @(negedge clk);
        dwrite(8'hE7);
        check("R11", mem_at(int'(17'h0A0A) | (2 << 14)), 8'hE7);
        check("R11", vram_addr, 17'h08A0B);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule